// File: doc/BRIEF.md
# SPI Register and RAM Access Slave

This block is the serial front end of a peripheral. An SPI master (mode 0: data sampled on the rising clock edge and changed on the falling edge, most significant bit first) uses it to read and write a small bank of control registers and a 256-byte RAM window. Each transaction sits inside one low period of an active-low chip select. The master sends a command byte and then a 16-bit address, high byte first. Data bytes follow, and the master may send as many as it needs before it releases the select.

Read commands place one dummy byte after the address. The slave uses that byte to fetch the first data byte. Write commands send data right after the address. Some commands step the address after every data byte and others stay on one address. Polling a status register and toggling an output register from a single burst both use the non-stepping commands. The serial pins are taken as already synchronous to `clk`, which samples them, so SCLK must stay in each phase for at least three `clk` periods. The serial pins carry only bytes and have no flow control. A master applies back-pressure by holding SCLK still or by releasing the select.

Top module: `spi_regram_slave`

## Requirements
- R1: Byte 1 of a transaction is the command, byte 2 the address high byte and byte 3 the address low byte. MISO stays 0 for all three.
- R2: For read commands, byte 4 is a wait byte whose MOSI content has no effect and whose MISO is 0. Read data appears from byte 5 on, MSB first, and MISO changes only after falling SCLK edges.
- R3: For write commands, byte 4 is the first data byte, and each data byte is committed once its eighth bit has been received.
- R4: Command 0x01 returns the register at the given address in every data byte, and the address does not advance.
- R5: Command 0x02 returns registers from successive addresses, adding 1 after each data byte.
- R6: Command 0x06 writes each data byte to successive register addresses, adding 1 after each byte.
- R7: Command 0x03 writes every data byte to the same register. The last byte remains, and neighbouring registers are untouched.
- R8: Commands 0x04 (write) and 0x08 (read) access RAM at sequential addresses inside the window 0x0400 to 0x04FF.
- R9: A RAM read at any address outside 0x0400 to 0x04FF returns 0xDE. This includes an address that a burst reaches by incrementing.
- R10: RAM writes outside the window are discarded. Registers occupy addresses 0x0000 to 0x000F. Register reads at any other address return 0x00, and register writes there change nothing.
- R11: Any other command byte makes the slave ignore the rest of the transaction. No write occurs, and MISO is 0 until the select is released.
- R12: Releasing the select in the middle of a byte discards that byte without any write. The next transaction starts again with a command byte.
- R13: After reset, MISO is 0 and all registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Active-low select that frames a transaction |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The hardest case to reach is the byte after the address stepping past the end of a region: a RAM burst going from 0x04FF to 0x0500, or a register burst going past 0x000F. To reach it, the bench writes the whole RAM window in one burst, then reads 258 bytes from its base and also reads across its lower edge. A second hard case is a select released partway through a byte. The bench drives a partial byte in a task that stops after a chosen bit count, then reads back the target register. The bench also sweeps every undefined command value and checks that none of them writes anything or drives MISO.

// File: rtl/spi_rr_pkg.sv
package spi_rr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [7:0] OP_POLL   = 8'h01;
  localparam logic [7:0] OP_RREAD  = 8'h02;
  localparam logic [7:0] OP_RSET   = 8'h03;
  localparam logic [7:0] OP_MWRITE = 8'h04;
  localparam logic [7:0] OP_RWRITE = 8'h06;
  localparam logic [7:0] OP_MREAD  = 8'h08;

  typedef struct packed {
    logic valid;
    logic is_read;
    logic is_ram;
    logic incr;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_CMD, ST_AH, ST_AL, ST_WAIT, ST_DATA, ST_DEAD
  } seq_st_e;

  function automatic cmd_t decode_op(input logic [7:0] op);
    cmd_t d;
    d = '0;
    case (op)
      OP_POLL:   begin d.valid = 1'b1; d.is_read = 1'b1; end
      OP_RREAD:  begin d.valid = 1'b1; d.is_read = 1'b1; d.incr = 1'b1; end
      OP_RSET:   begin d.valid = 1'b1; end
      OP_RWRITE: begin d.valid = 1'b1; d.incr = 1'b1; end
      OP_MREAD:  begin d.valid = 1'b1; d.is_read = 1'b1; d.is_ram = 1'b1; d.incr = 1'b1; end
      OP_MWRITE: begin d.valid = 1'b1; d.is_ram = 1'b1; d.incr = 1'b1; end
      default:   d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/spi_rr_shifter.sv
module spi_rr_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         mosi,
  input  logic [W-1:0] tx_byte,
  output logic         byte_done,
  output logic [W-1:0] rx_byte,
  output logic         miso
);
  localparam int CW = $clog2(W);

  logic          sclk_q;
  logic          rise, fall;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sr, tx_sr;

  assign rise = sclk & ~sclk_q & ~cs_n;
  assign fall = ~sclk & sclk_q & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      rx_sr  <= '0;
      tx_sr  <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        cnt   <= '0;
        tx_sr <= '0;
      end else begin
        if (rise) begin
          cnt   <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
          rx_sr <= {rx_sr[W-2:0], mosi};
        end
        if (fall) begin
          // a falling edge with the bit count at zero closes a byte
          if (cnt == '0) tx_sr <= tx_byte;
          else           tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
      end
    end
  end

  assign byte_done = rise && (cnt == CW'(W-1));
  assign rx_byte   = {rx_sr[W-2:0], mosi};
  assign miso      = tx_sr[W-1];
endmodule

// File: rtl/spi_rr_seq.sv
module spi_rr_seq
  import spi_rr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                byte_done,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   addr,
  output cmd_t                cmd,
  output seq_st_e             state,
  output logic                wr_en,
  output logic [BYTE_W-1:0]   wr_data,
  output logic [BYTE_W-1:0]   tx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;
      cmd   <= '0;
      addr  <= '0;
    end else if (cs_n) begin
      state <= ST_CMD;
      cmd   <= '0;
      addr  <= '0;
    end else if (byte_done) begin
      case (state)
        ST_CMD: begin
          cmd   <= decode_op(rx_byte);
          state <= decode_op(rx_byte).valid ? ST_AH : ST_DEAD;
        end
        ST_AH: begin
          addr[ADDR_W-1:BYTE_W] <= rx_byte;
          state <= ST_AL;
        end
        ST_AL: begin
          addr[BYTE_W-1:0] <= rx_byte;
          state <= cmd.is_read ? ST_WAIT : ST_DATA;
        end
        ST_WAIT: state <= ST_DATA;
        ST_DATA: if (cmd.incr) addr <= addr + ADDR_W'(1);
        default: state <= ST_DEAD;
      endcase
    end
  end

  assign wr_en   = byte_done && (state == ST_DATA) && cmd.valid && !cmd.is_read && !cs_n;
  assign wr_data = rx_byte;
  assign tx_byte = ((state == ST_DATA) && cmd.is_read) ? rd_data : '0;
endmodule

// File: rtl/spi_rr_store.sv
module spi_rr_store
  import spi_rr_pkg::*;
#(
  parameter int              REG_COUNT = 16,
  parameter int              RAM_BASE  = 'h0400,
  parameter int              RAM_DEPTH = 256,
  parameter logic [BYTE_W-1:0] FILL    = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_ram,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int RIW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int RAW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

  logic [BYTE_W-1:0] regs [REG_COUNT];
  logic [BYTE_W-1:0] ram  [RAM_DEPTH];
  logic              reg_hit, ram_hit;
  logic [RIW-1:0]    reg_idx;
  logic [RAW-1:0]    ram_off;

  assign reg_hit = 32'(addr) < REG_COUNT;
  assign ram_hit = (32'(addr) >= RAM_BASE) && (32'(addr) < RAM_BASE + RAM_DEPTH);
  assign reg_idx = addr[RIW-1:0];
  assign ram_off = RAW'(32'(addr) - RAM_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wr_en && !is_ram && reg_hit) begin
      regs[reg_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && is_ram && ram_hit) ram[ram_off] <= wr_data;
  end

  always_comb begin
    if (is_ram) rd_data = ram_hit ? ram[ram_off] : FILL;
    else        rd_data = reg_hit ? regs[reg_idx] : '0;
  end
endmodule

// File: rtl/spi_regram_slave.sv
module spi_regram_slave
  import spi_rr_pkg::*;
#(
  parameter int              REG_COUNT = 16,
  parameter int              RAM_BASE  = 'h0400,
  parameter int              RAM_DEPTH = 256,
  parameter logic [7:0]      FILL      = 8'hDE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic              byte_done, wr_en;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data;
  logic [ADDR_W-1:0] cur_addr;
  cmd_t              cur_cmd;
  seq_st_e           seq_state;

  spi_rr_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
  );

  spi_rr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_data(rd_data), .addr(cur_addr), .cmd(cur_cmd),
    .state(seq_state), .wr_en(wr_en), .wr_data(wr_data), .tx_byte(tx_byte)
  );

  spi_rr_store #(
    .REG_COUNT(REG_COUNT), .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH), .FILL(FILL)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .addr(cur_addr), .is_ram(cur_cmd.is_ram),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_regram_slave_chk.sv
module spi_regram_slave_chk
  import spi_rr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input seq_st_e           st,
  input logic [ADDR_W-1:0] addr,
  input cmd_t              cmd,
  input logic              byte_done,
  input logic              wr_en
);
  AST_HDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD || st == ST_AH || st == ST_AL || st == ST_WAIT) |-> !miso); // R1
  AST_WR_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st == ST_DATA && !cmd.is_read)); // R3
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_DATA && !cmd.incr && !cs_n) |=> $stable(addr)); // R4
  AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_DATA && cmd.incr && !cs_n) |=> addr == $past(addr) + ADDR_W'(1)); // R5
  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD) |-> (!wr_en && !miso)); // R11
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == ST_CMD && !wr_en)); // R12
endmodule

bind spi_regram_slave spi_regram_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .st(seq_state),
  .addr(cur_addr), .cmd(cur_cmd), .byte_done(byte_done), .wr_en(wr_en)
);

// File: tb/spi_regram_slave_tb.sv
module spi_regram_slave_tb;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int vectors = 0;
  int fails = 0;
  logic [7:0] txb [0:299];
  logic [7:0] rxb [0:299];

  always #5 clk = ~clk;

  spi_regram_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] regv(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] ramv(input int i);
    return 8'(((i * 13) & 255) ^ 8'hA5);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] t, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = t[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic run(input int n);
    logic [7:0] r;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      spi_bits(txb[k], 8, r);
      rxb[k] = r;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a);
    for (int k = 0; k < 300; k++) txb[k] = 8'h00;
    txb[0] = op;
    txb[1] = a[15:8];
    txb[2] = a[7:0];
  endtask

  task automatic partial(input int nfull, input int bits);
    logic [7:0] r;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nfull; k++) spi_bits(txb[k], 8, r);
    spi_bits(txb[nfull], bits, r);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 miso in reset", {7'd0, miso}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 miso after reset", {7'd0, miso}, 8'h00);

    // R13: registers cleared; R1/R2 header and wait byte silent
    hdr(8'h02, 16'h0000); txb[3] = 8'hFF;
    run(20);
    for (int k = 0; k < 4; k++) chk("R1 R2 header quiet", rxb[k], 8'h00);
    for (int i = 0; i < 16; i++) chk("R13 reset reg", rxb[4+i], 8'h00);

    // R3 R6: sequential register write, data right after the address
    hdr(8'h06, 16'h0000);
    for (int i = 0; i < 16; i++) txb[3+i] = regv(i);
    run(19);

    // R5 R2 R10: sequential read past the last register, wait byte MOSI busy
    hdr(8'h02, 16'h0000); txb[3] = 8'hA5;
    for (int k = 4; k < 22; k++) txb[k] = 8'hFF;
    run(22);
    for (int i = 0; i < 16; i++) chk("R5 R6 seq reg read", rxb[4+i], regv(i));
    chk("R10 reg beyond bank", rxb[20], 8'h00);
    chk("R10 reg beyond bank", rxb[21], 8'h00);

    // R4: polling every register
    for (int i = 0; i < 16; i++) begin
      hdr(8'h01, 16'(i)); txb[3] = 8'h5A;
      run(7);
      for (int k = 4; k < 7; k++) chk("R4 poll", rxb[k], regv(i));
    end

    // R7: repeated write to one register
    hdr(8'h03, 16'h0007); txb[3] = 8'hAA; txb[4] = 8'h55; txb[5] = 8'hC3;
    run(6);
    hdr(8'h02, 16'h0006);
    run(7);
    chk("R7 neighbour below", rxb[4], regv(6));
    chk("R7 last byte kept", rxb[5], 8'hC3);
    chk("R7 neighbour above", rxb[6], regv(8));

    // R10: register writes outside the bank change nothing
    hdr(8'h06, 16'h0100); txb[3] = 8'hFF; txb[4] = 8'hFF;
    run(5);
    hdr(8'h06, 16'h0020); txb[3] = 8'hEE;
    run(4);
    hdr(8'h02, 16'h0100);
    run(5);
    chk("R10 unmapped reg read", rxb[4], 8'h00);
    hdr(8'h02, 16'h0000);
    run(20);
    for (int i = 0; i < 16; i++)
      chk("R10 bank untouched", rxb[4+i], (i == 7) ? 8'hC3 : regv(i));

    // R8: fill RAM window, R9: burst steps out of it
    hdr(8'h04, 16'h0400);
    for (int i = 0; i < 256; i++) txb[3+i] = ramv(i);
    run(259);
    hdr(8'h08, 16'h0400); txb[3] = 8'h3C;
    run(262);
    for (int i = 0; i < 256; i++) chk("R8 ram burst", rxb[4+i], ramv(i));
    chk("R9 past window top", rxb[260], 8'hDE);
    chk("R9 past window top", rxb[261], 8'hDE);

    // R9: entering the window from below, and far away
    hdr(8'h08, 16'h03FF);
    run(7);
    chk("R9 below window", rxb[4], 8'hDE);
    chk("R8 window base", rxb[5], ramv(0));
    chk("R8 window next", rxb[6], ramv(1));
    hdr(8'h08, 16'h1234);
    run(6);
    chk("R9 far address", rxb[4], 8'hDE);
    chk("R9 far address", rxb[5], 8'hDE);

    // R10: RAM writes outside the window discarded (no aliasing)
    hdr(8'h04, 16'h0500); txb[3] = 8'h11; txb[4] = 8'h22;
    run(5);
    hdr(8'h04, 16'h0300); txb[3] = 8'h33;
    run(4);
    hdr(8'h08, 16'h0400);
    run(6);
    chk("R10 ram no alias", rxb[4], ramv(0));
    chk("R10 ram no alias", rxb[5], ramv(1));
    hdr(8'h08, 16'h0500);
    run(5);
    chk("R10 ram outside", rxb[4], 8'hDE);

    // R11: sweep every undefined opcode
    for (int op = 0; op < 256; op++) begin
      if (op == 1 || op == 2 || op == 3 || op == 4 || op == 6 || op == 8) continue;
      hdr(8'(op), 16'h0003); txb[3] = 8'hEE; txb[4] = 8'hEE;
      run(5);
      chk("R11 undefined op miso", rxb[3] | rxb[4] | rxb[1], 8'h00);
    end
    hdr(8'h02, 16'h0000);
    run(20);
    for (int i = 0; i < 16; i++)
      chk("R11 bank untouched", rxb[4+i], (i == 7) ? 8'hC3 : regv(i));

    // R12: select released mid data byte, then mid command byte
    hdr(8'h06, 16'h0005); txb[3] = 8'hFF;
    partial(3, 5);
    hdr(8'h01, 16'h0005);
    run(5);
    chk("R12 partial byte no write", rxb[4], regv(5));
    hdr(8'h02, 16'h0000);
    partial(0, 3);
    hdr(8'h01, 16'h0009);
    run(5);
    chk("R12 restart after abort", rxb[4], regv(9));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule